// File: doc/BRIEF.md
# Paged Address Decoder with Bus Control

This block decodes bus cycles for a 16-bit embedded controller whose address and data share the bus. It takes the latched address, a fetch qualifier and the cycle strobes. The fetch qualifier splits the space into two 64K pages. Program fetches go to a code page that holds 64K bytes of program memory. Data accesses go to a second page. That page holds a 2K-byte scratch-pad SRAM, a single-byte output latch and two peripheral windows of 256 bytes each.

For every cycle the block drives these outputs:
- one active-low chip select for the region that matches;
- a flag telling the processor whether the cycle is 16 or 8 bits wide;
- a ready line, which a small counter holds low for three clocks after the address strobe of a slow peripheral cycle.

Memory cycles and output-latch cycles never wait.

Top module: `paged_bus_decoder`

## Requirements
- R1: With `fetch_q`=1 every address asserts `cs_prog_n` (while a strobe is active), and `bus16` is 1.
- R2: With `fetch_q`=0, addresses 0x0000..0x07FF assert `cs_sram_n`, and `bus16` is 0.
- R3: With `fetch_q`=0, only address 0x8000 asserts `cs_olat_n`; 0x8001 asserts nothing; `bus16` is 0.
- R4: With `fetch_q`=0, 0xC000..0xC0FF asserts `cs_per0_n` with `bus16`=1, and 0xC100..0xC1FF asserts `cs_per1_n` with `bus16`=0.
- R5: All chip selects are active low and all stay high while both `rd_n` and `wr_n` are high; `bus16` follows the decode regardless of strobes.
- R6: A data-page address outside every region asserts no chip select, gives `bus16`=0 and leaves `ready` high.
- R7: `ale` sampled high at a clock edge with a peripheral window decoded drives `ready` low for exactly 3 clocks after that edge, then high; an `ale` during the count does not restart it.
- R8: `ale` on a program, SRAM or output-latch cycle leaves `ready` high.
- R9: At most one chip select is low at any time.
- R10: After reset `ready` is high and, with idle strobes, all chip selects are high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_lat | input | 16 | Latched bus address |
| fetch_q | input | 1 | 1 = instruction fetch (code page), 0 = data page |
| ale | input | 1 | Address latch strobe, one clock at cycle start |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| cs_prog_n | output | 1 | Program memory select, active low |
| cs_sram_n | output | 1 | Scratch-pad SRAM select, active low |
| cs_olat_n | output | 1 | Output latch select, active low |
| cs_per0_n | output | 1 | 16-bit peripheral select, active low |
| cs_per1_n | output | 1 | 8-bit peripheral select, active low |
| bus16 | output | 1 | 1 = 16-bit cycle, 0 = 8-bit cycle |
| ready | output | 1 | 0 = insert wait state |

## Verification
The wait window is the hardest behaviour to reach. It needs `ale` and the address of a peripheral window to be present at the same clock edge. After that, `ready` has to be followed over four edges while the strobe stays active. The directed part of the bench drives each access kind this way. It samples `ready` at each falling edge after the strobe, so a window that is one clock too long or too short shows up.

The bench also sends a second `ale` partway through a count, which shows that the count is not restarted. It runs fast cycles through the same sequence to show that they never pull `ready` low. One of these uses the code page with a peripheral-range address.

// File: rtl/paged_bus_decoder.sv
module paged_bus_decoder #(
  parameter int ADDR_W      = 16,
  parameter int SRAM_BYTES  = 2048,
  parameter int OLAT_ADDR   = 'h8000,
  parameter int PER0_BASE   = 'hC000,
  parameter int PER1_BASE   = 'hC100,
  parameter int PER_WIN     = 256,
  parameter int WAIT_STATES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_lat,
  input  logic              fetch_q,
  input  logic              ale,
  input  logic              rd_n,
  input  logic              wr_n,
  output logic              cs_prog_n,
  output logic              cs_sram_n,
  output logic              cs_olat_n,
  output logic              cs_per0_n,
  output logic              cs_per1_n,
  output logic              bus16,
  output logic              ready
);
  localparam int CW = $clog2(WAIT_STATES + 1);
  localparam logic [ADDR_W:0] SRAM_END = (ADDR_W+1)'(SRAM_BYTES);
  localparam logic [ADDR_W:0] OLAT_A   = (ADDR_W+1)'(OLAT_ADDR);
  localparam logic [ADDR_W:0] P0_LO    = (ADDR_W+1)'(PER0_BASE);
  localparam logic [ADDR_W:0] P0_HI    = (ADDR_W+1)'(PER0_BASE + PER_WIN);
  localparam logic [ADDR_W:0] P1_LO    = (ADDR_W+1)'(PER1_BASE);
  localparam logic [ADDR_W:0] P1_HI    = (ADDR_W+1)'(PER1_BASE + PER_WIN);
  localparam logic [CW-1:0]   WAIT_LD  = CW'(WAIT_STATES);

  logic [ADDR_W:0] a;
  logic strobe, hit_prog, hit_sram, hit_olat, hit_per0, hit_per1, slow;
  logic [CW-1:0] wcnt;

  assign a        = {1'b0, addr_lat};
  assign strobe   = ~rd_n | ~wr_n;
  assign hit_prog = fetch_q;
  assign hit_sram = ~fetch_q & (a < SRAM_END);
  assign hit_olat = ~fetch_q & (a == OLAT_A);
  assign hit_per0 = ~fetch_q & (a >= P0_LO) & (a < P0_HI);
  assign hit_per1 = ~fetch_q & (a >= P1_LO) & (a < P1_HI);
  assign slow     = hit_per0 | hit_per1;

  assign cs_prog_n = ~(strobe & hit_prog);
  assign cs_sram_n = ~(strobe & hit_sram);
  assign cs_olat_n = ~(strobe & hit_olat);
  assign cs_per0_n = ~(strobe & hit_per0);
  assign cs_per1_n = ~(strobe & hit_per1);
  assign bus16     = hit_prog | hit_per0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   wcnt <= '0;
    else if (wcnt != '0)          wcnt <= wcnt - 1'b1;
    else if (ale && slow)         wcnt <= WAIT_LD;
  end

  assign ready = (wcnt == '0);
endmodule

// File: rtl/paged_bus_decoder_chk.sv
module paged_bus_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] addr_lat,
  input logic        fetch_q,
  input logic        ale,
  input logic        rd_n,
  input logic        wr_n,
  input logic        cs_prog_n,
  input logic        cs_sram_n,
  input logic        cs_olat_n,
  input logic        cs_per0_n,
  input logic        cs_per1_n,
  input logic        bus16,
  input logic        ready
);
  logic [4:0] cs_n;
  logic       per_addr;
  assign cs_n     = {cs_prog_n, cs_sram_n, cs_olat_n, cs_per0_n, cs_per1_n};
  assign per_addr = !fetch_q && (addr_lat[15:9] == 7'h60);

  AST_CS_ONE_HOT: assert property (@(posedge clk) disable iff (!rst_n) $countones(~cs_n) <= 1); // R9
  AST_IDLE_NO_CS: assert property (@(posedge clk) disable iff (!rst_n) (rd_n && wr_n) |-> (cs_n == 5'h1F)); // R5
  AST_PROG_WIDE: assert property (@(posedge clk) disable iff (!rst_n) !cs_prog_n |-> bus16); // R1
  AST_SRAM_NARROW: assert property (@(posedge clk) disable iff (!rst_n) !cs_sram_n |-> !bus16); // R2
  AST_WAIT_START: assert property (@(posedge clk) disable iff (!rst_n) (ale && ready && per_addr) |=> !ready); // R7
  AST_WAIT_LEN: assert property (@(posedge clk) disable iff (!rst_n) $fell(ready) |=> !ready ##1 !ready ##1 ready); // R7
  AST_FAST_NO_WAIT: assert property (@(posedge clk) disable iff (!rst_n) (ale && ready && !per_addr) |=> ready); // R8
endmodule

bind paged_bus_decoder paged_bus_decoder_chk u_chk (.*);

// File: tb/paged_bus_decoder_tb.sv
module paged_bus_decoder_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] addr_lat = '0;
  logic fetch_q = 1'b0, ale = 1'b0, rd_n = 1'b1, wr_n = 1'b1;
  logic cs_prog_n, cs_sram_n, cs_olat_n, cs_per0_n, cs_per1_n, bus16, ready;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  paged_bus_decoder u_dut (.*);

  // {fetch, addr, rd_n, wr_n, cs{prog,sram,olat,per0,per1}, bus16}
  localparam int NV = 14;
  localparam logic [24:0] VEC [NV] = '{
    {1'b1, 16'h1234, 2'b01, 5'b01111, 1'b1},  // R1
    {1'b1, 16'hFFFF, 2'b01, 5'b01111, 1'b1},  // R1
    {1'b0, 16'h0000, 2'b01, 5'b10111, 1'b0},  // R2
    {1'b0, 16'h07FF, 2'b10, 5'b10111, 1'b0},  // R2
    {1'b0, 16'h0800, 2'b01, 5'b11111, 1'b0},  // R6
    {1'b0, 16'h8000, 2'b10, 5'b11011, 1'b0},  // R3
    {1'b0, 16'h8001, 2'b10, 5'b11111, 1'b0},  // R3
    {1'b0, 16'hC000, 2'b01, 5'b11101, 1'b1},  // R4
    {1'b0, 16'hC0FF, 2'b01, 5'b11101, 1'b1},  // R4
    {1'b0, 16'hC100, 2'b10, 5'b11110, 1'b0},  // R4
    {1'b0, 16'hC1FF, 2'b01, 5'b11110, 1'b0},  // R4
    {1'b0, 16'hC200, 2'b01, 5'b11111, 1'b0},  // R6
    {1'b1, 16'h1234, 2'b11, 5'b11111, 1'b1},  // R5
    {1'b0, 16'hC000, 2'b11, 5'b11111, 1'b1}   // R5
  };

  function automatic logic [4:0] cs_now();
    return {cs_prog_n, cs_sram_n, cs_olat_n, cs_per0_n, cs_per1_n};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_run(input string tag, input logic f, input logic [15:0] a, input int lows,
                          input bit second_ale);
    @(negedge clk);
    fetch_q = f; addr_lat = a; rd_n = 1'b0; ale = 1'b1;
    @(negedge clk);
    ale = 1'b0;
    for (int i = 0; i < 5; i++) begin
      #1 chk(tag, 32'(ready), (i < lows) ? 32'd0 : 32'd1);
      if (second_ale && i == 1) ale = 1'b1;
      @(negedge clk);
      ale = 1'b0;
    end
    rd_n = 1'b1;
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 ready in reset", 32'(ready), 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    #1 chk("R10 ready after reset", 32'(ready), 32'd1);
    chk("R10 cs idle", 32'(cs_now()), 32'h1F);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {fetch_q, addr_lat, rd_n, wr_n} = VEC[i][24:6];
      #1;
      chk($sformatf("R1-5 vec%0d cs", i), 32'(cs_now()), 32'(VEC[i][5:1]));
      chk($sformatf("vec%0d bus16", i), 32'(bus16), 32'(VEC[i][0]));
      chk($sformatf("R6 vec%0d ready", i), 32'(ready), 32'd1);
    end
    @(negedge clk); rd_n = 1'b1; wr_n = 1'b1;

    wait_run("R7 per0 wait", 1'b0, 16'hC010, 3, 1'b0);
    wait_run("R7 per1 wait", 1'b0, 16'hC1F0, 3, 1'b0);
    wait_run("R7 ale mid count", 1'b0, 16'hC000, 3, 1'b1);
    wait_run("R8 olat no wait", 1'b0, 16'h8000, 0, 1'b0);
    wait_run("R8 sram no wait", 1'b0, 16'h0100, 0, 1'b0);
    wait_run("R8 prog no wait", 1'b1, 16'hC000, 0, 1'b0);
    wait_run("R6 unmatched no wait", 1'b0, 16'h4000, 0, 1'b0);

    @(negedge clk);
    fetch_q = 1'b0; addr_lat = 16'hC000; rd_n = 1'b0;
    #1 chk("R4 per0 read cs", 32'(cs_per0_n), 32'd0);
    chk("R9 single cs", 32'(cs_now()), 32'h1D);
    rd_n = 1'b1;
    #1 chk("R5 strobe release", 32'(cs_now()), 32'h1F);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule